// File: doc/BRIEF.md
# Sampling Converter Serial Readout Port

This block is the device-side digital port of a 16-bit sampling converter. A host starts a conversion with a rising edge on the convert strobe. The level that the serial input held just before that edge picks how the result is read back. A high level selects chip-select readout. In that mode the result leaves on the serial output only while a select condition holds: the serial input low in four-wire use, or the convert strobe low in three-wire use. A low level selects daisy-chain readout. In that mode the serial input feeds the tail of the output shift register, so several units on one serial clock form one long shift register toward the host.

The analog conversion is stood in for by a fixed cycle-count timer and a parallel sample input. The sample is captured when the timer expires. During the conversion the output enable is low. When the conversion ends, the port can place a low start bit ahead of the data, which the host can use as a ready interrupt. Whether it does so depends on the mode and on pin levels. All pins are oversampled by the system clock. Edges are found from registered copies of the pins, and the data advances by one bit on each falling edge of the serial clock, MSB first.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, sdo_oe_o and sdo_o are both 0.
- R2: A rising edge on cnv_i starts a conversion and drops sdo_oe_o. Counting from the clock edge that registers the new cnv_i level, the result becomes visible on the (CONV_CYCLES+1)-th following clock edge and no earlier.
- R3: The mode is taken from the sdi_i level registered one clock before the registered cnv_i rise. A 1 selects chip-select mode and a 0 selects chain mode. When sdi_i and cnv_i switch together, chain mode results.
- R4: The 16-bit sample is sent MSB first. Each falling edge of sck_i moves the next bit onto sdo_o, and no other event does.
- R5: In chain mode, sdo_oe_o is 1 from the end of the conversion onward. Bits arriving on sdi_i enter behind the local data, so three cascaded units deliver 48 bits: the nearest unit first, then the one upstream of it, then the farthest.
- R6: In chip-select mode, after the conversion sdo_oe_o is 1 only while cnv_i is 0 or sdi_i is 0. Falling edges of sck_i while this select condition is false do not advance the data.
- R7: In chip-select mode, a start bit precedes the data exactly when cnv_i or sdi_i is 0 as the conversion ends.
- R8: In chain mode, a start bit precedes the data exactly when sck_i was 1 at the convert edge (the level registered one clock before the registered cnv_i rise).
- R9: The start bit drives sdo_o to 0 from the end of the conversion. The first falling edge of sck_i replaces it with the sample MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Convert strobe; the rising edge starts a conversion; three-wire select |
| sdi_i | input | 1 | Mode strap at the convert edge; four-wire select; chain cascade input |
| sck_i | input | 1 | Serial clock from the host; data advances on its falling edge |
| sample_i | input | 16 | Parallel result captured at the end of the conversion |
| sdo_o | output | 1 | Serial data out; 0 whenever disabled |
| sdo_oe_o | output | 1 | Output enable; 0 stands for high impedance |

## Verification
The bench first cascades three units in chain mode and checks all 48 bits in order. A unit that shifted in the wrong register stage would duplicate or drop one bit at each 16-bit seam. It ties sdi_i to cnv_i and expects chain mode. A design that sampled sdi_i after the edge would land in chip-select mode and keep the output disabled. It checks the output enable on the exact cycles around the end of the conversion, which catches off-by-one timers. It also clocks sck_i while chip-select is inactive and then expects the full word from the MSB, so a port that shifted unselected would show a later bit. The start bit is tested against each of its three enabling conditions and against its absence. A missing, stuck or inverted start bit shifts or corrupts the first bits read.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_READY = 2'd2
    } asp_state_e;

    typedef enum logic {
        MODE_CHAIN  = 1'b0,
        MODE_SELECT = 1'b1
    } asp_mode_e;

    typedef struct packed {
        logic cnv;
        logic sdi;
        logic sck;
    } pin_set_t;

    localparam logic START_LEVEL = 1'b0;

    // Chip-select readout is active when either select line is low.
    function automatic logic select_active(pin_set_t p);
        return (!p.cnv) || (!p.sdi);
    endfunction

endpackage

// File: rtl/asp_pin_sampler.sv
module asp_pin_sampler
    import asp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cnv_pin,
    input  logic     sdi_pin,
    input  logic     sck_pin,
    output pin_set_t now_q,
    output pin_set_t prev_q,
    output logic     cnv_rise,
    output logic     sck_fall
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            now_q  <= '{cnv: cnv_pin, sdi: sdi_pin, sck: sck_pin};
            prev_q <= now_q;
        end
    end

    assign cnv_rise = now_q.cnv && !prev_q.cnv;
    assign sck_fall = !now_q.sck && prev_q.sck;

endmodule

// File: rtl/asp_conv_timer.sv
module asp_conv_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == LAST) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/asp_shifter.sv
module asp_shifter
    import asp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_start,
    input  logic         shift,
    input  logic         ser_in,
    output logic         bit_out,
    output logic         start_pending
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr            <= '0;
            start_pending <= 1'b0;
        end else if (load) begin
            sr            <= load_data;
            start_pending <= load_start;
        end else if (shift) begin
            if (start_pending) begin
                start_pending <= 1'b0;
            end else begin
                sr <= {sr[W-2:0], ser_in};
            end
        end
    end

    assign bit_out = start_pending ? START_LEVEL : sr[W-1];

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import asp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnv_i,
    input  logic              sdi_i,
    input  logic              sck_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    pin_set_t   now_q;
    pin_set_t   prev_q;
    logic       cnv_rise;
    logic       sck_fall;
    logic       conv_done;
    asp_state_e state;
    asp_mode_e  mode_q;
    logic       chain_busy_q;
    logic       in_conv;
    logic       ready_now;
    logic       chain_ready;
    logic       port_sel;
    logic       load_en;
    logic       load_start;
    logic       shift_en;
    logic       ser_in;
    logic       bit_out;
    logic       start_pend;

    asp_pin_sampler u_pins (
        .clk      (clk),
        .rst      (rst),
        .cnv_pin  (cnv_i),
        .sdi_pin  (sdi_i),
        .sck_pin  (sck_i),
        .now_q    (now_q),
        .prev_q   (prev_q),
        .cnv_rise (cnv_rise),
        .sck_fall (sck_fall)
    );

    asp_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (cnv_rise),
        .done  (conv_done)
    );

    // Mode and chain busy strap use pin levels from before the edge,
    // which gives the hold behaviour needed when sdi is tied to cnv.
    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            mode_q       <= MODE_CHAIN;
            chain_busy_q <= 1'b0;
        end else if (cnv_rise) begin
            state        <= ST_CONV;
            mode_q       <= prev_q.sdi ? MODE_SELECT : MODE_CHAIN;
            chain_busy_q <= prev_q.sck;
        end else if (state == ST_CONV && conv_done) begin
            state <= ST_READY;
        end
    end

    assign in_conv     = (state == ST_CONV);
    assign ready_now   = (state == ST_READY);
    assign chain_ready = ready_now && (mode_q == MODE_CHAIN);
    assign port_sel    = (mode_q == MODE_CHAIN) || select_active(now_q);

    assign load_en    = in_conv && conv_done && !cnv_rise;
    assign load_start = (mode_q == MODE_SELECT) ? select_active(now_q)
                                                : chain_busy_q;
    assign shift_en   = ready_now && sck_fall && port_sel;
    assign ser_in     = (mode_q == MODE_CHAIN) ? now_q.sdi : 1'b0;

    asp_shifter #(.W(DATA_W)) u_shift (
        .clk           (clk),
        .rst           (rst),
        .load          (load_en),
        .load_data     (sample_i),
        .load_start    (load_start),
        .shift         (shift_en),
        .ser_in        (ser_in),
        .bit_out       (bit_out),
        .start_pending (start_pend)
    );

    assign sdo_oe_o = ready_now && port_sel;
    assign sdo_o    = sdo_oe_o ? bit_out : 1'b0;

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk
    import asp_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic cnv_rise,
    input logic in_conv,
    input logic ready_now,
    input logic chain_ready,
    input logic shift_en,
    input logic bit_out,
    input logic start_pend,
    input logic sdo_o,
    input logic sdo_oe_o
);

    a_r2_hidden_after_start: assert property (@(posedge clk) disable iff (rst)
        cnv_rise |=> !sdo_oe_o);

    a_r2_hidden_converting: assert property (@(posedge clk) disable iff (rst)
        in_conv |-> !sdo_oe_o);

    a_r5_chain_drives: assert property (@(posedge clk) disable iff (rst)
        chain_ready |-> sdo_oe_o);

    a_r9_start_level: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe_o && start_pend) |-> (sdo_o == START_LEVEL));

    a_r4_hold_between_falls: assert property (@(posedge clk) disable iff (rst)
        (ready_now && !shift_en && !cnv_rise) |=> $stable(bit_out));

endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cnv_rise    (cnv_rise),
    .in_conv     (in_conv),
    .ready_now   (ready_now),
    .chain_ready (chain_ready),
    .shift_en    (shift_en),
    .bit_out     (bit_out),
    .start_pend  (start_pend),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;

    localparam int W    = 16;
    localparam int CONV = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnv = 1'b0;
    logic         sck = 1'b0;
    logic         tb_sdi = 1'b0;
    logic         up_sdi = 1'b0;
    logic         cascade = 1'b0;
    logic [W-1:0] samp0 = '0;
    logic [W-1:0] samp1 = '0;
    logic [W-1:0] samp2 = '0;
    logic         sdo0, oe0, sdo1, oe1, sdo, oe;
    logic         uut_sdi;
    int           vectors = 0;
    int           fails = 0;
    bit           finished = 0;

    always #10 clk = ~clk;

    assign uut_sdi = cascade ? sdo1 : tb_sdi;

    adc_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) up0 (
        .clk(clk), .rst(rst), .cnv_i(cnv), .sdi_i(up_sdi), .sck_i(sck),
        .sample_i(samp0), .sdo_o(sdo0), .sdo_oe_o(oe0));

    adc_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) up1 (
        .clk(clk), .rst(rst), .cnv_i(cnv), .sdi_i(sdo0), .sck_i(sck),
        .sample_i(samp1), .sdo_o(sdo1), .sdo_oe_o(oe1));

    adc_serial_port #(.DATA_W(W), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst(rst), .cnv_i(cnv), .sdi_i(uut_sdi), .sck_i(sck),
        .sample_i(samp2), .sdo_o(sdo), .sdo_oe_o(oe));

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic sck_pulse();
        sck = 1'b1;
        wait_n(3);
        sck = 1'b0;
        wait_n(3);
    endtask

    // Reads a word bit by bit, sampling before each falling edge.
    task automatic read_word(input string tag, input logic [W-1:0] exp);
        for (int i = W - 1; i >= 0; i--) begin
            chk(tag, sdo, exp[i]);
            sck_pulse();
        end
    endtask

    task automatic start_conv(input logic sdi_lvl, input logic sck_lvl);
        tb_sdi = sdi_lvl;
        sck    = sck_lvl;
        wait_n(3);
        cnv = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", oe, 1'b0);
        chk("R1 sdo after reset", sdo, 1'b0);
    endtask

    task automatic t_cascade();
        cascade = 1'b1;
        up_sdi  = 1'b0;
        samp0 = 16'h1234;
        samp1 = 16'hBEEF;
        samp2 = 16'hC3A5;
        start_conv(1'b0, 1'b0);
        wait_n(CONV + 1);
        chk("R2 oe still low at last conversion cycle", oe, 1'b0);
        wait_n(1);
        chk("R2 oe high once result ready", oe, 1'b1);
        chk("R5 chain enabled", oe, 1'b1);
        read_word("R5 cascade near unit / R8 no start", samp2);
        read_word("R5 cascade middle unit", samp1);
        read_word("R5 cascade far unit", samp0);
        cnv = 1'b0;
        cascade = 1'b0;
        wait_n(3);
    endtask

    task automatic t_cs_three_wire_plain();
        samp2 = 16'hA5C3;
        start_conv(1'b1, 1'b0);
        wait_n(CONV + 4);
        chk("R3 select mode leaves output off", oe, 1'b0);
        sck_pulse();
        sck_pulse();
        chk("R6 oe off while unselected", oe, 1'b0);
        cnv = 1'b0;
        wait_n(3);
        chk("R6 oe on when cnv low", oe, 1'b1);
        read_word("R4 R6 R7 word from MSB, no start", samp2);
        cnv = 1'b1;
        wait_n(3);
        chk("R6 oe off when cnv high", oe, 1'b0);
        cnv = 1'b0;
        wait_n(3);
    endtask

    task automatic t_cs_busy_cnv();
        samp2 = 16'h9F01;
        start_conv(1'b1, 1'b0);
        wait_n(3);
        cnv = 1'b0;
        wait_n(CONV + 4);
        chk("R7 oe at end with cnv low", oe, 1'b1);
        chk("R7 R9 start bit level", sdo, 1'b0);
        sck_pulse();
        read_word("R9 data after start bit", samp2);
        wait_n(3);
    endtask

    task automatic t_cs_busy_sdi();
        samp2 = 16'hC00F;
        start_conv(1'b1, 1'b0);
        wait_n(3);
        tb_sdi = 1'b0;
        wait_n(CONV + 4);
        chk("R7 oe at end with sdi low", oe, 1'b1);
        chk("R7 start bit four-wire", sdo, 1'b0);
        sck_pulse();
        read_word("R7 four-wire data", samp2);
        tb_sdi = 1'b1;
        wait_n(3);
        chk("R6 oe off when sdi high", oe, 1'b0);
        cnv = 1'b0;
        tb_sdi = 1'b0;
        wait_n(3);
    endtask

    task automatic t_tied();
        samp2 = 16'h8001;
        sck = 1'b0;
        tb_sdi = 1'b0;
        wait_n(3);
        cnv = 1'b1;
        tb_sdi = 1'b1;
        wait_n(CONV + 4);
        chk("R3 tied pins choose chain", oe, 1'b1);
        read_word("R3 tied chain data", samp2);
        cnv = 1'b0;
        tb_sdi = 1'b0;
        wait_n(3);
    endtask

    task automatic t_chain_busy();
        samp2 = 16'hF00D;
        start_conv(1'b0, 1'b1);
        wait_n(CONV + 4);
        chk("R8 chain oe", oe, 1'b1);
        chk("R8 chain start bit", sdo, 1'b0);
        sck = 1'b0;
        wait_n(3);
        read_word("R9 chain data after start bit", samp2);
        cnv = 1'b0;
        wait_n(3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        t_reset();
        t_cascade();
        t_cs_three_wire_plain();
        t_cs_busy_cnv();
        t_cs_busy_sdi();
        t_tied();
        t_chain_busy();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule